// File: doc/BRIEF.md
# Pipelined Byte-Lane Burst RAM Datapath

This block is the storage and data path behind a synchronous burst RAM. A cycle controller hands it, once per clock, a word address, a four-bit lane write strobe and a read request. Each word is 36 bits wide and is split into four 9-bit lanes, each lane being eight data bits plus that lane's parity bit. A write touches only the lanes whose strobe bit is set. The write is held in a data-in register for one cycle and then committed to the array. A read that arrives in the following cycle picks up the held lanes through a forwarding path.

A read goes through two register stages. The first stage captures the addressed word and the second stage drives the output, so drivers turn on two edges after a read and turn off two edges after the last one. The block does not drive a real tri-state pin. It exposes the output word together with a drive-enable. The drive-enable is gated at once by an active-low output enable, is forced off in the cycle after any sampled write, and is off while the block is powered down.

A sleep input powers the block down after two consecutive high samples, and the array contents are kept through sleep. Wake-up takes two cycles, and an access start requested during those two cycles raises a one-cycle protocol error flag.

Top module: `burst_ram_datapath`

## Requirements
- R1: A write with strobe bit k set replaces bits [9k+8:9k] of the addressed word, which are lane k's data byte plus its parity bit at 9k+8. Lanes whose strobe bit is clear keep their old value.
- R2: A read sampled at edge N (rd_vld_i high, no strobe bit set, not powered down) puts the addressed word on dq_o after edge N+1. With oe_n_i low, dq_oe_o is high in that cycle.
- R3: dq_oe_o stays high on back-to-back reads and falls two edges after the edge that sampled the last read.
- R4: oe_n_i high forces dq_oe_o low at once, without waiting for a clock edge. oe_n_i low restores it within the same cycle.
- R5: In the cycle after an edge that samples a write, dq_oe_o is low whatever the value of oe_n_i.
- R6: A read sampled at the edge right after a write to the same address returns the merged word, with the new lanes and the untouched old lanes.
- R7: sleep_i sampled high at two consecutive edges sets powered_dn_o after the second edge. While powered_dn_o is high, dq_oe_o is low and reads and writes are ignored.
- R8: Array contents written before sleep read back unchanged after wake-up.
- R9: Once sleep_i is sampled low, powered_dn_o stays high for two more cycles and falls at the following edge. start_i sampled high at an edge in that window makes proto_err_o high for exactly the next cycle.
- R10: While reset is applied and for two edges after it is released, dq_oe_o, powered_dn_o and proto_err_o are low and dq_o is zero.
- R11: When a write strobe and rd_vld_i are sampled at the same edge, the write is performed and the read is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_i | input | ADDR_W | Registered word address from the cycle controller |
| lane_we_i | input | LANES | Per-lane write strobe, bit k selects lane k |
| wdata_i | input | LANES*LANE_W | Write word, lane k at bits [9k+8:9k] |
| rd_vld_i | input | 1 | Read request for addr_i |
| start_i | input | 1 | Access start requested by the controller (used for wake-window error) |
| oe_n_i | input | 1 | Asynchronous active-low output enable |
| sleep_i | input | 1 | Power-down request |
| dq_o | output | LANES*LANE_W | Output register contents |
| dq_oe_o | output | 1 | Output drive enable |
| powered_dn_o | output | 1 | Block is asleep or in its wake window |
| proto_err_o | output | 1 | Start requested during wake window |

## Verification
The array is first filled at every address with full-width writes. It is then read in a back-to-back burst, which separates a correct two-stage latency from a one- or three-stage one and shows the drive-enable trailing off two edges after the last read. All sixteen strobe values are written to one address with a read after each. This separates correct lane masking, parity bit included, from masking that is too wide or too narrow, and the immediate read-after-write also exercises the forwarding path. Mixed read/write cycles, mid-cycle output-enable toggling and a sleep entry, blocked write and wake sequence with a start request inside the wake window tell apart write priority, asynchronous gating, write-forced turn-off and the exact two-cycle sleep timing.

// File: rtl/burst_ram_pkg.sv
package burst_ram_pkg;

  typedef enum logic [2:0] {
    SLP_AWAKE = 3'd0,
    SLP_DOZE  = 3'd1,
    SLP_DOWN  = 3'd2,
    SLP_WAKE1 = 3'd3,
    SLP_WAKE2 = 3'd4
  } slp_state_e;

endpackage

// File: rtl/burst_ram_rst_sync.sv
module burst_ram_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sn
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sn = stage2_q;

endmodule

// File: rtl/burst_ram_sleep_ctl.sv
module burst_ram_sleep_ctl
  import burst_ram_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_i,
  input  logic start_i,
  output logic pdn_o,
  output logic perr_o
);

  slp_state_e state_q;
  slp_state_e state_d;
  logic       perr_q;
  logic       perr_d;
  logic       in_wake;

  assign in_wake = (state_q == SLP_WAKE1) || (state_q == SLP_WAKE2);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SLP_AWAKE: state_d = sleep_i ? SLP_DOZE  : SLP_AWAKE;
      SLP_DOZE:  state_d = sleep_i ? SLP_DOWN  : SLP_AWAKE;
      SLP_DOWN:  state_d = sleep_i ? SLP_DOWN  : SLP_WAKE1;
      SLP_WAKE1: state_d = sleep_i ? SLP_DOWN  : SLP_WAKE2;
      SLP_WAKE2: state_d = sleep_i ? SLP_DOWN  : SLP_AWAKE;
      default:   state_d = SLP_AWAKE;
    endcase
  end

  assign perr_d = in_wake && start_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SLP_AWAKE;
      perr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      perr_q  <= perr_d;
    end
  end

  assign pdn_o  = (state_q == SLP_DOWN) || in_wake;
  assign perr_o = perr_q;

endmodule

// File: rtl/burst_ram_lane.sv
module burst_ram_lane #(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LANE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [LANE_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] cells_q [DEPTH];
  logic              fwd_hit;

  // Array is not reset: contents survive reset and sleep alike.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      cells_q[wr_addr] <= wr_data;
    end
  end

  // A lane still held in the data-in register is newer than the array.
  assign fwd_hit = wr_en && (wr_addr == rd_addr);
  assign rd_data = fwd_hit ? wr_data : cells_q[rd_addr];

endmodule

// File: rtl/burst_ram_rdpipe.sv
module burst_ram_rdpipe #(
  parameter int WORD_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] dout_o,
  output logic              vld_o
);

  logic [WORD_W-1:0] stg1_q;
  logic [WORD_W-1:0] stg1_d;
  logic [WORD_W-1:0] stg2_q;
  logic [WORD_W-1:0] stg2_d;
  logic              v1_q;
  logic              v2_q;

  always_comb begin
    stg1_d = stg1_q;
    if (cap_i) begin
      stg1_d = word_i;
    end
    stg2_d = stg2_q;
    if (v1_q) begin
      stg2_d = stg1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1_q <= '0;
      stg2_q <= '0;
      v1_q   <= 1'b0;
      v2_q   <= 1'b0;
    end else begin
      stg1_q <= stg1_d;
      stg2_q <= stg2_d;
      v1_q   <= cap_i;
      v2_q   <= v1_q;
    end
  end

  assign dout_o = stg2_q;
  assign vld_o  = v2_q;

endmodule

// File: rtl/burst_ram_datapath.sv
module burst_ram_datapath #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES-1:0]        lane_we_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic                    rd_vld_i,
  input  logic                    start_i,
  input  logic                    oe_n_i,
  input  logic                    sleep_i,
  output logic [LANES*LANE_W-1:0] dq_o,
  output logic                    dq_oe_o,
  output logic                    powered_dn_o,
  output logic                    proto_err_o
);

  localparam int WORD_W = LANES * LANE_W;

  logic              rst_sn;
  logic              pdn;
  logic              wr_go;
  logic              rd_go;

  logic              pend_vld_q;
  logic [LANES-1:0]  pend_lanes_q;
  logic [LANES-1:0]  pend_lanes_d;
  logic [ADDR_W-1:0] pend_addr_q;
  logic [ADDR_W-1:0] pend_addr_d;
  logic [WORD_W-1:0] pend_data_q;
  logic [WORD_W-1:0] pend_data_d;

  logic [WORD_W-1:0] rd_word;
  logic [WORD_W-1:0] pipe_dout;
  logic              pipe_vld;

  burst_ram_rst_sync u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .rst_sn (rst_sn)
  );

  burst_ram_sleep_ctl u_sleep (
    .clk     (clk),
    .rst_n   (rst_sn),
    .sleep_i (sleep_i),
    .start_i (start_i),
    .pdn_o   (pdn),
    .perr_o  (proto_err_o)
  );

  // Writes take priority over a read in the same cycle; nothing runs while down.
  assign wr_go = (|lane_we_i) && !pdn;
  assign rd_go = rd_vld_i && !wr_go && !pdn;

  always_comb begin
    pend_lanes_d = pend_lanes_q;
    pend_addr_d  = pend_addr_q;
    pend_data_d  = pend_data_q;
    if (wr_go) begin
      pend_lanes_d = lane_we_i;
      pend_addr_d  = addr_i;
      pend_data_d  = wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      pend_vld_q   <= 1'b0;
      pend_lanes_q <= '0;
      pend_addr_q  <= '0;
      pend_data_q  <= '0;
    end else begin
      pend_vld_q   <= wr_go;
      pend_lanes_q <= pend_lanes_d;
      pend_addr_q  <= pend_addr_d;
      pend_data_q  <= pend_data_d;
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    burst_ram_lane #(
      .ADDR_W (ADDR_W),
      .LANE_W (LANE_W)
    ) u_lane (
      .clk     (clk),
      .wr_en   (pend_vld_q && pend_lanes_q[k]),
      .wr_addr (pend_addr_q),
      .wr_data (pend_data_q[k*LANE_W +: LANE_W]),
      .rd_addr (addr_i),
      .rd_data (rd_word[k*LANE_W +: LANE_W])
    );
  end

  burst_ram_rdpipe #(
    .WORD_W (WORD_W)
  ) u_rdpipe (
    .clk    (clk),
    .rst_n  (rst_sn),
    .cap_i  (rd_go),
    .word_i (rd_word),
    .dout_o (pipe_dout),
    .vld_o  (pipe_vld)
  );

  assign dq_o         = pipe_dout;
  assign dq_oe_o      = !oe_n_i && pipe_vld && !pend_vld_q && !pdn;
  assign powered_dn_o = pdn;

endmodule

// File: rtl/burst_ram_chk.sv
module burst_ram_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_sn,
  input logic [LANES-1:0] lane_we_i,
  input logic             rd_vld_i,
  input logic             oe_n_i,
  input logic             sleep_i,
  input logic             start_i,
  input logic             dq_oe_o,
  input logic             powered_dn_o,
  input logic             proto_err_o
);

  assert_write_blanks_R5: assert property (@(posedge clk) disable iff (!rst_sn)
    ((|lane_we_i) && !powered_dn_o) |=> !dq_oe_o);

  assert_oe_gates_R4: assert property (@(posedge clk) disable iff (!rst_sn)
    oe_n_i |-> !dq_oe_o);

  assert_read_two_deep_R3: assert property (@(posedge clk) disable iff (!rst_sn)
    dq_oe_o |-> $past(rd_vld_i, 2));

  assert_down_quiet_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    powered_dn_o |-> !dq_oe_o);

  assert_sleep_entry_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    (sleep_i && !powered_dn_o) ##1 sleep_i |=> powered_dn_o);

  assert_err_cause_R9: assert property (@(posedge clk) disable iff (!rst_sn)
    proto_err_o |-> ($past(start_i) && $past(powered_dn_o)));

  assert_reset_quiet_R10: assert property (@(posedge clk)
    !rst_sn |-> (!dq_oe_o && !proto_err_o && !powered_dn_o));

endmodule

bind burst_ram_datapath burst_ram_chk #(
  .LANES (LANES)
) u_chk (
  .clk          (clk),
  .rst_sn       (rst_sn),
  .lane_we_i    (lane_we_i),
  .rd_vld_i     (rd_vld_i),
  .oe_n_i       (oe_n_i),
  .sleep_i      (sleep_i),
  .start_i      (start_i),
  .dq_oe_o      (dq_oe_o),
  .powered_dn_o (powered_dn_o),
  .proto_err_o  (proto_err_o)
);

// File: tb/burst_ram_datapath_tb_top.sv
module burst_ram_datapath_tb_top;

  localparam int CLK_P  = 10;
  localparam int ADDR_W = 6;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk;
  logic              rst_n;
  logic [ADDR_W-1:0] addr_i;
  logic [LANES-1:0]  lane_we_i;
  logic [WORD_W-1:0] wdata_i;
  logic              rd_vld_i;
  logic              start_i;
  logic              oe_n_i;
  logic              sleep_i;
  logic [WORD_W-1:0] dq_o;
  logic              dq_oe_o;
  logic              powered_dn_o;
  logic              proto_err_o;

  burst_ram_datapath #(
    .ADDR_W (ADDR_W),
    .LANES  (LANES),
    .LANE_W (LANE_W)
  ) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr_i       (addr_i),
    .lane_we_i    (lane_we_i),
    .wdata_i      (wdata_i),
    .rd_vld_i     (rd_vld_i),
    .start_i      (start_i),
    .oe_n_i       (oe_n_i),
    .sleep_i      (sleep_i),
    .dq_o         (dq_o),
    .dq_oe_o      (dq_oe_o),
    .powered_dn_o (powered_dn_o),
    .proto_err_o  (proto_err_o)
  );

  initial clk = 1'b0;
  always #(CLK_P / 2) clk = ~clk;

  int    errors = 0;
  int    checks = 0;
  bit    done   = 1'b0;
  string tag    = "R10";

  task automatic chk(input bit ok, input string rq, input logic [WORD_W-1:0] act,
                     input logic [WORD_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", rq, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [WORD_W-1:0] mdl_mem [int];
  int                rcnt = 0;
  int                mst  = 0;   // 0 awake, 1 doze, 2 down, 3/4 wake window
  bit                mv1, mv2, mwrq, mperr;
  logic [WORD_W-1:0] md1, md2;

  always @(posedge clk) begin : model
    bit                pdn_m;
    bit                wr_m;
    bit                rd_m;
    logic [WORD_W-1:0] w;
    if (!rst_n || rcnt < 2) begin
      if (!rst_n) rcnt = 0;
      else        rcnt = rcnt + 1;
      mst = 0; mv1 = 0; mv2 = 0; mwrq = 0; mperr = 0; md1 = '0; md2 = '0;
    end else begin
      pdn_m = (mst >= 2);
      wr_m  = (lane_we_i != '0) && !pdn_m;
      rd_m  = rd_vld_i && !wr_m && !pdn_m;
      mperr = (mst == 3 || mst == 4) && (start_i == 1'b1);
      if (mv1) md2 = md1;
      mv2 = mv1;
      if (rd_m) md1 = mdl_mem.exists(int'(addr_i)) ? mdl_mem[int'(addr_i)] : '0;
      mv1  = rd_m;
      mwrq = wr_m;
      if (wr_m) begin
        w = mdl_mem.exists(int'(addr_i)) ? mdl_mem[int'(addr_i)] : '0;
        for (int k = 0; k < LANES; k++)
          if (lane_we_i[k]) w[k*LANE_W +: LANE_W] = wdata_i[k*LANE_W +: LANE_W];
        mdl_mem[int'(addr_i)] = w;
      end
      case (mst)
        0: mst = sleep_i ? 1 : 0;
        1: mst = sleep_i ? 2 : 0;
        2: mst = sleep_i ? 2 : 3;
        3: mst = sleep_i ? 2 : 4;
        default: mst = sleep_i ? 2 : 0;
      endcase
    end
  end

  // Compare every cycle, away from the active edge.
  always @(negedge clk) begin : compare
    bit exp_oe;
    if (!done) begin
      exp_oe = !oe_n_i && mv2 && !mwrq && (mst < 2);
      chk(dq_oe_o == exp_oe, {tag, " dq_oe_o"}, WORD_W'(dq_oe_o), WORD_W'(exp_oe));
      chk(powered_dn_o == (mst >= 2), "R7 R9 powered_dn_o", WORD_W'(powered_dn_o),
          WORD_W'(mst >= 2));
      chk(proto_err_o == mperr, "R9 proto_err_o", WORD_W'(proto_err_o), WORD_W'(mperr));
      if (exp_oe) chk(dq_o == md2, {tag, " dq_o"}, dq_o, md2);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic drive(input logic [ADDR_W-1:0] a, input logic [LANES-1:0] we,
                       input logic [WORD_W-1:0] wd, input bit rd, input bit sl,
                       input bit st, input bit oen);
    @(negedge clk);
    #1;
    addr_i    = a;
    lane_we_i = we;
    wdata_i   = wd;
    rd_vld_i  = rd;
    sleep_i   = sl;
    start_i   = st;
    oe_n_i    = oen;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive('0, '0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  function automatic logic [WORD_W-1:0] pat(input int a);
    logic [WORD_W-1:0] r;
    for (int k = 0; k < LANES; k++) r[k*LANE_W +: LANE_W] = LANE_W'(a * 37 + k * 101 + 5);
    return r;
  endfunction

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin : watchdog
    #(CLK_P * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  // ---------------- test sequence ----------------
  initial begin : main
    rst_n = 1'b0; addr_i = '0; lane_we_i = '0; wdata_i = '0; rd_vld_i = 1'b0;
    start_i = 1'b0; oe_n_i = 1'b0; sleep_i = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    // R10: quiet outputs while reset is held
    chk(dq_oe_o == 1'b0 && powered_dn_o == 1'b0 && proto_err_o == 1'b0, "R10 flags",
        WORD_W'({dq_oe_o, powered_dn_o, proto_err_o}), '0);
    chk(dq_o == '0, "R10 dq_o", dq_o, '0);
    rst_n = 1'b1;
    idle(4);

    // Fill the whole array (last address included) with full-width writes.
    tag = "R1";
    for (int a = 0; a < DEPTH; a++) drive(ADDR_W'(a), '1, pat(a), 1'b0, 1'b0, 1'b0, 1'b0);
    idle(2);

    // R2 R3: back-to-back burst of reads, then drivers trail off.
    tag = "R2 R3";
    for (int a = 0; a < 8; a++) drive(ADDR_W'(a), '0, '0, 1'b1, 1'b0, 1'b0, 1'b0);
    drive(ADDR_W'(DEPTH - 1), '0, '0, 1'b1, 1'b0, 1'b0, 1'b0);
    idle(4);

    // R1 R6: every strobe value on one address, read right after each write.
    tag = "R1 R6";
    for (int s = 0; s < 16; s++) begin
      drive(ADDR_W'(3), LANES'(s), ~pat(s + 50), 1'b0, 1'b0, 1'b0, 1'b0);
      drive(ADDR_W'(3), '0, '0, 1'b1, 1'b0, 1'b0, 1'b0);
      idle(1);
    end
    idle(2);

    // R5: write in the middle of a read stream turns drivers off for a cycle.
    tag = "R5";
    drive(ADDR_W'(10), '0, '0, 1'b1, 1'b0, 1'b0, 1'b0);
    drive(ADDR_W'(11), '0, '0, 1'b1, 1'b0, 1'b0, 1'b0);
    drive(ADDR_W'(12), 4'b0101, pat(99), 1'b0, 1'b0, 1'b0, 1'b0);
    drive(ADDR_W'(12), '0, '0, 1'b1, 1'b0, 1'b0, 1'b0);
    // R5: drivers are off in the cycle after the sampled write
    chk(dq_oe_o == 1'b0, "R5 directed", WORD_W'(dq_oe_o), '0);
    idle(3);

    // R11: read and write strobe sampled together.
    tag = "R11";
    drive(ADDR_W'(20), 4'b1000, pat(77), 1'b1, 1'b0, 1'b0, 1'b0);
    drive(ADDR_W'(21), '0, '0, 1'b1, 1'b0, 1'b0, 1'b0);
    drive(ADDR_W'(20), '0, '0, 1'b1, 1'b0, 1'b0, 1'b0);
    idle(4);

    // R4: output enable acts without a clock edge.
    tag = "R4";
    for (int i = 0; i < 3; i++) drive(ADDR_W'(5), '0, '0, 1'b1, 1'b0, 1'b0, 1'b0);
    drive(ADDR_W'(5), '0, '0, 1'b1, 1'b0, 1'b0, 1'b0);
    #1 oe_n_i = 1'b1;
    #1 chk(dq_oe_o == 1'b0, "R4 oe high", WORD_W'(dq_oe_o), '0);
    oe_n_i = 1'b0;
    #1 chk(dq_oe_o == 1'b1, "R4 oe low", WORD_W'(dq_oe_o), WORD_W'(1));
    drive(ADDR_W'(6), '0, '0, 1'b1, 1'b0, 1'b0, 1'b1);
    idle(3);

    // R7 R8 R9: sleep entry, blocked write, wake window with a start request.
    tag = "R7";
    drive(ADDR_W'(0), '0, '0, 1'b0, 1'b1, 1'b0, 1'b0);
    drive(ADDR_W'(0), '0, '0, 1'b0, 1'b1, 1'b0, 1'b0);
    // R7: not yet down after a single high sample
    chk(powered_dn_o == 1'b0, "R7 one sample", WORD_W'(powered_dn_o), '0);
    drive(ADDR_W'(7), '1, ~pat(7), 1'b0, 1'b1, 1'b0, 1'b0);
    // R7: down after two high samples
    chk(powered_dn_o == 1'b1, "R7 two samples", WORD_W'(powered_dn_o), WORD_W'(1));
    drive(ADDR_W'(7), '0, '0, 1'b1, 1'b1, 1'b0, 1'b0);
    tag = "R9";
    drive(ADDR_W'(0), '0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
    drive(ADDR_W'(0), '0, '0, 1'b0, 1'b0, 1'b1, 1'b0);
    drive(ADDR_W'(0), '0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
    // R9: error raised for the start seen in the wake window
    chk(proto_err_o == 1'b1, "R9 err raised", WORD_W'(proto_err_o), WORD_W'(1));
    chk(powered_dn_o == 1'b1, "R9 still waking", WORD_W'(powered_dn_o), WORD_W'(1));
    drive(ADDR_W'(0), '0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk(proto_err_o == 1'b0, "R9 err one cycle", WORD_W'(proto_err_o), '0);
    chk(powered_dn_o == 1'b0, "R9 awake", WORD_W'(powered_dn_o), '0);
    tag = "R8";
    drive(ADDR_W'(7), '0, '0, 1'b1, 1'b0, 1'b0, 1'b0);
    drive(ADDR_W'(DEPTH - 1), '0, '0, 1'b1, 1'b0, 1'b0, 1'b0);
    drive(ADDR_W'(0), '0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
    // R8: contents kept and the write attempted while down was ignored
    chk(dq_oe_o == 1'b1 && dq_o == pat(7), "R8 kept", dq_o, pat(7));
    idle(4);

    finish_run();
  end

endmodule